// File: doc/BRIEF.md
# Selectable Adder-Based Arithmetic Unit

This block performs seven arithmetic operations with a single ripple-carry adder. Operand A always goes to the first adder input. A two-bit source select decides what reaches the second adder input: B, the bitwise inverse of B, all zeros or all ones. A carry-in bit completes the operation code. The combinational result and its carry-out are available in the same cycle as the inputs.

A thin registered stage captures the result into a destination register when a load enable is high at a rising clock edge. A surrounding datapath uses that register as the destination of a register transfer. The width is a parameter with a default of 8 bits.

Top module: `arith_unit`

## Requirements
- R1: With opSel=2'b00 the second adder input is B, so {carryOut,sumOut} equals A+B+carryIn as a WIDTH+1 bit sum (add, and add with carry).
- R2: With opSel=2'b01 the second adder input is ~B. With carryIn=1, sumOut is A−B modulo 2^WIDTH and carryOut is 1 exactly when A>=B. With carryIn=0, sumOut is A−B−1 (subtract with borrow).
- R3: With opSel=2'b10 the second adder input is zero. carryIn=0 passes A through with carryOut=0, and carryIn=1 gives A+1.
- R4: With opSel=2'b11 the second adder input is all ones. carryIn=0 gives A−1, and carryIn=1 passes A through with carryOut=1.
- R5: Incrementing all ones gives zero with carryOut=1. Decrementing zero gives all ones with carryOut=0.
- R6: sumOut and carryOut are combinational and follow the inputs without a clock edge.
- R7: destOut takes the value of sumOut at a rising clock edge where loadEn=1, and keeps its value at every edge where loadEn=0.
- R8: While rstN=0, destOut is cleared to zero.
- R9: With opSel=2'b10 or 2'b11, the value of B has no effect on sumOut or carryOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the destination register |
| rstN | input | 1 | Active-low reset, clears the destination register |
| opA | input | WIDTH | Operand fed straight to the adder |
| opB | input | WIDTH | Operand routed, inverted or replaced by the source select |
| opSel | input | 2 | Second-input source: 00 B, 01 ~B, 10 zeros, 11 ones |
| carryIn | input | 1 | Carry into the least significant stage |
| loadEn | input | 1 | Load strobe for the destination register |
| sumOut | output | WIDTH | Combinational result |
| carryOut | output | 1 | Carry out of the most significant stage |
| destOut | output | WIDTH | Destination register contents |

## Verification
A broken source steering or a broken carry link shows on sumOut and carryOut in the same cycle as the stimulus. The bench samples those ports shortly after each input change, so a fault is seen on the first pattern that exercises it. Wrap patterns (all ones plus one, zero minus one) and mixed-sign subtractions expose a broken high-order carry link. A fault in the destination register shows on destOut one edge after a load, or after an edge with load low at which the value should have held.

// File: rtl/arith_pkg.sv
package arith_pkg;

  typedef enum logic [1:0] {
    SRC_B    = 2'b00,
    SRC_NOTB = 2'b01,
    SRC_ZERO = 2'b10,
    SRC_ONES = 2'b11
  } ySrcE;

  // strobes from control to datapath; no source flag set means zeros
  typedef struct packed {
    logic passB;
    logic invB;
    logic forceOnes;
    logic carryIn;
    logic loadEn;
  } strobeS;

endpackage

// File: rtl/arith_ctrl.sv
module arith_ctrl
  import arith_pkg::*;
(
  input  logic [1:0] opSel,
  input  logic       carryIn,
  input  logic       loadEn,
  output strobeS     stb
);

  ySrcE src;

  always_comb begin
    src           = ySrcE'(opSel);
    stb           = '0;
    stb.carryIn   = carryIn;
    stb.loadEn    = loadEn;
    unique case (src)
      SRC_B:    stb.passB     = 1'b1;
      SRC_NOTB: stb.invB      = 1'b1;
      SRC_ZERO: ;
      SRC_ONES: stb.forceOnes = 1'b1;
      default:  ;
    endcase
  end

  // R9: at most one source drives the second adder input
  always_comb begin
    ysrc_excl_chk: assert ($onehot0({stb.passB, stb.invB, stb.forceOnes}));
  end

endmodule

// File: rtl/arith_fullbit.sv
module arith_fullbit (
  input  logic xIn,
  input  logic yIn,
  input  logic cIn,
  output logic sOut,
  output logic cOut
);

  logic halfSum;

  always_comb begin
    halfSum = xIn ^ yIn;
    sOut    = halfSum ^ cIn;
    cOut    = (xIn & yIn) | (halfSum & cIn);
  end

endmodule

// File: rtl/arith_datapath.sv
module arith_datapath
  import arith_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  strobeS           stb,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut,
  output logic [WIDTH-1:0] destOut
);

  localparam int EXT = WIDTH + 1;

  logic [WIDTH-1:0] ySel;
  logic [WIDTH:0]   carryChain;

  assign carryChain[0] = stb.carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign ySel[i] = (stb.passB & opB[i]) | (stb.invB & ~opB[i]) | stb.forceOnes;

    arith_fullbit u_bit (
      .xIn  (opA[i]),
      .yIn  (ySel[i]),
      .cIn  (carryChain[i]),
      .sOut (sumOut[i]),
      .cOut (carryChain[i+1])
    );
  end

  assign carryOut = carryChain[WIDTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          destOut <= '0;
    else if (stb.loadEn) destOut <= sumOut;
  end

  // R1
  add_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.passB |-> ({carryOut, sumOut} ==
      (EXT'({1'b0, opA}) + EXT'({1'b0, opB}) + EXT'(stb.carryIn))));

  // R2
  sub_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.invB |-> ({carryOut, sumOut} ==
      (EXT'({1'b0, opA}) + EXT'({1'b0, ~opB}) + EXT'(stb.carryIn))));

  // R5
  inc_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.passB && !stb.invB && !stb.forceOnes && stb.carryIn && (&opA))
      |-> (carryOut && sumOut == '0));

  // R5
  dec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.forceOnes && !stb.carryIn && opA == '0)
      |-> (!carryOut && (&sumOut)));

  // R7
  load_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadEn |=> (destOut == $past(sumOut)));

  // R7
  load_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadEn |=> $stable(destOut));

endmodule

// File: rtl/arith_unit.sv
module arith_unit
  import arith_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [1:0]       opSel,
  input  logic             carryIn,
  input  logic             loadEn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut,
  output logic [WIDTH-1:0] destOut
);

  strobeS stb;

  arith_ctrl u_ctrl (
    .opSel   (opSel),
    .carryIn (carryIn),
    .loadEn  (loadEn),
    .stb     (stb)
  );

  arith_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .opA      (opA),
    .opB      (opB),
    .stb      (stb),
    .sumOut   (sumOut),
    .carryOut (carryOut),
    .destOut  (destOut)
  );

endmodule

// File: tb/tb_arith_unit.sv
module tb_arith_unit;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [1:0]   opSel = 2'b00;
  logic         carryIn = 1'b0;
  logic         loadEn = 1'b0;
  logic [W-1:0] sumOut;
  logic         carryOut;
  logic [W-1:0] destOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  arith_unit #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opSel(opSel),
    .carryIn(carryIn), .loadEn(loadEn),
    .sumOut(sumOut), .carryOut(carryOut), .destOut(destOut)
  );

  // expected {carry,sum} taken from the requirement table
  function automatic logic [W:0] refCalc(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [1:0] s, input logic c);
    logic [W-1:0] y;
    case (s)
      2'b00:   y = b;
      2'b01:   y = ~b;
      2'b10:   y = '0;
      default: y = '1;
    endcase
    return {1'b0, a} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic applyOp(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [1:0] s, input logic c);
    @(negedge clk);
    opA = a; opB = b; opSel = s; carryIn = c; loadEn = 1'b0;
    #1;
  endtask

  task automatic opCheck(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [1:0] s, input logic c);
    logic [W:0] e;
    applyOp(a, b, s, c);
    e = refCalc(a, b, s, c);
    chk(req, 16'({carryOut, sumOut}), 16'(e));
  endtask

  task automatic test_reset();
    chk("R8 reset", 16'(destOut), 16'h0);
  endtask

  task automatic test_add();
    opCheck("R1 add", 8'h12, 8'h34, 2'b00, 1'b0);
    opCheck("R1 add carry", 8'hF0, 8'h20, 2'b00, 1'b1);
    opCheck("R1 add max", 8'hFF, 8'hFF, 2'b00, 1'b1);
    applyOp(8'h80, 8'h80, 2'b00, 1'b0);
    chk("R1 add msb carry", 16'({carryOut, sumOut}), 16'h100);
  endtask

  task automatic test_sub();
    applyOp(8'd5, 8'd3, 2'b01, 1'b1);
    chk("R2 sub ge", 16'({carryOut, sumOut}), 16'h102);
    applyOp(8'd3, 8'd5, 2'b01, 1'b1);
    chk("R2 sub lt", 16'({carryOut, sumOut}), 16'h0FE);
    applyOp(8'd5, 8'd3, 2'b01, 1'b0);
    chk("R2 sub borrow", 16'(sumOut), 16'h01);
    opCheck("R2 sub equal", 8'h7A, 8'h7A, 2'b01, 1'b1);
  endtask

  task automatic test_zero_src();
    applyOp(8'h5C, 8'hAA, 2'b10, 1'b0);
    chk("R3 transfer", 16'({carryOut, sumOut}), 16'h05C);
    applyOp(8'h5C, 8'hAA, 2'b10, 1'b1);
    chk("R3 increment", 16'({carryOut, sumOut}), 16'h05D);
    applyOp(8'hFF, 8'h00, 2'b10, 1'b1);
    chk("R5 inc wrap", 16'({carryOut, sumOut}), 16'h100);
  endtask

  task automatic test_ones_src();
    applyOp(8'h40, 8'h11, 2'b11, 1'b0);
    chk("R4 decrement", 16'({carryOut, sumOut}), 16'h13F);
    applyOp(8'h40, 8'h11, 2'b11, 1'b1);
    chk("R4 transfer", 16'({carryOut, sumOut}), 16'h140);
    applyOp(8'h00, 8'h11, 2'b11, 1'b0);
    chk("R5 dec wrap", 16'({carryOut, sumOut}), 16'h0FF);
  endtask

  task automatic test_ignore_b();
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] bv = 8'(k * 8'h55);
      applyOp(8'h3C, bv, 2'b10, 1'b1);
      chk("R9 zero src ignores B", 16'({carryOut, sumOut}), 16'h03D);
      applyOp(8'h3C, bv, 2'b11, 1'b0);
      chk("R9 ones src ignores B", 16'({carryOut, sumOut}), 16'h13B);
    end
  endtask

  task automatic test_comb();
    applyOp(8'h01, 8'h01, 2'b00, 1'b0);
    chk("R6 comb first", 16'(sumOut), 16'h02);
    #3 opB = 8'h10; #1;
    chk("R6 comb no edge", 16'(sumOut), 16'h11);
  endtask

  task automatic test_load();
    applyOp(8'h21, 8'h02, 2'b00, 1'b0);
    loadEn = 1'b1;
    @(posedge clk); #1;
    chk("R7 load", 16'(destOut), 16'h23);
    @(negedge clk);
    loadEn = 1'b0; opA = 8'h90;
    repeat (2) @(posedge clk);
    #1;
    chk("R7 hold", 16'(destOut), 16'h23);
    @(negedge clk);
    opSel = 2'b11; carryIn = 1'b0; opA = 8'h00; loadEn = 1'b1;
    @(posedge clk); #1;
    chk("R7 load dec wrap", 16'(destOut), 16'hFF);
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic test_sweep();
    for (int k = 0; k < 64; k++) begin
      logic [W-1:0] a = 8'(k * 37 + 5);
      logic [W-1:0] b = 8'(k * 91 + 13);
      opCheck(((k % 2) == 0) ? "R1 sweep" : "R2 sweep", a, b, (k % 2) == 0 ? 2'b00 : 2'b01, k[2]);
      opCheck(((k % 2) == 0) ? "R3 sweep" : "R4 sweep", a, b, (k % 2) == 0 ? 2'b10 : 2'b11, k[3]);
    end
  endtask

  task automatic test_reset_again();
    @(negedge clk);
    rstN = 1'b0; loadEn = 1'b1; #1;
    chk("R8 async clear", 16'(destOut), 16'h0);
    @(posedge clk); #1;
    chk("R8 held in reset", 16'(destOut), 16'h0);
    @(negedge clk);
    loadEn = 1'b0; rstN = 1'b1;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    test_reset();
    @(negedge clk);
    rstN = 1'b1;
    test_add();
    test_sub();
    test_zero_src();
    test_ones_src();
    test_ignore_b();
    test_comb();
    test_load();
    test_sweep();
    test_reset_again();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule